// File: doc/BRIEF.md
# Buffered Dual-Channel PWM Timer

This block is a 16-bit up counter fed through a power-of-two clock prescaler, with a halt control and a one-shot clear. The counter wraps to zero after it reaches a programmable period value. Two output-compare channels watch the counter. Each channel turns compare and overflow events into a PWM level on its own pin. Each channel has a mode field, a toggle-at-wrap enable, a compare-action field and a full-duty flag. Software programs the block through a small synchronous register bus. Writes take effect at the clock edge on which `wr_en` is high, and reads are combinational.

When channel 0 selects buffered mode, the two channels form one pair. Both compare registers then feed the channel 0 pin and take turns as the active pulse width. A small state machine tracks which register is active. It has five states: `LK_SOLO` (not linked), `LK_USE0` (channel 0 register active), `LK_USE0_NXT1` (channel 1 register written, swap pending), `LK_USE1` (channel 1 register active) and `LK_USE1_NXT0` (channel 0 register written, swap pending). It moves as follows:
- `LK_SOLO` goes to `LK_USE0` when the link is enabled.
- `LK_USE0` goes to `LK_USE0_NXT1` on a write to the channel 1 register.
- `LK_USE1` goes to `LK_USE1_NXT0` on a write to the channel 0 register.
- Each pending state completes its swap at the next wrap.
- Every state returns to `LK_SOLO` when the link is dropped.

Each channel's output runs its own two-state machine, `OUT_LOW` and `OUT_HIGH`.

Top module: `pwm_pair_timer`

## Requirements
- R1: The halt bit (address 0, bit 0) freezes both the counter and the prescaler while it is set. The counter value is read at address 2.
- R2: Writing 1 to the clear bit (address 0, bit 1) zeroes the counter and the prescaler at that write. The bit does not hold its value and always reads back as 0.
- R3: The counter steps through 0..PERIOD and then returns to 0, where PERIOD is set at address 1. The prescaler select (address 0, bits 4:2, value k) makes the counter advance once every 2^k clocks.
- R4: Each channel has a control word (channel 0 at address 3, channel 1 at address 5) and a compare register (channel 0 at address 4, channel 1 at address 6). The control word holds mode in bits 1:0 (bit 1 = buffered, bit 0 = unbuffered), toggle-at-wrap in bit 2, compare action in bits 4:3 and full-duty in bit 5. A compare event occurs on a counter step taken while the counter equals the active compare value.
- R5: In unbuffered mode with toggle-at-wrap set, compare action 2'b10 drives the pin low on compare, so the pin is high for C+1 of every PERIOD+1 counter steps. Compare action 2'b11 drives the pin high on compare, so the pin is high for PERIOD-C of them.
- R6: With toggle-at-wrap clear, the pin never changes at a wrap. The duty cycle is 0%, and the pin stays at the level the compare drives.
- R7: With full-duty and toggle-at-wrap both set, the pin stays at the pulse level, which is the inverse of the compare level, giving 100% duty.
- R8: When a compare and a wrap happen on the same counter step, the compare level wins.
- R9: Compare action 2'b00 leaves the pin undriven, and it reads low.
- R10: Setting channel 0 mode bit 1 links the pair, whatever mode bit 0 holds. While linked, the channel 0 compare register is active first, the channel 1 control word is ignored, and pin 1 stays low.
- R11: While linked, a write to the inactive compare register becomes the active pulse width from the next wrap.
- R12: While linked, a write to the active compare register changes the pulse width at once and does not swap the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| pwm_out | output | 2 | PWM pins for channel 0 and channel 1 |

## Verification
A compare event and a counter wrap can fall on the same counter step. This happens when the compare value equals the period. It also happens, in effect, when the compare value is zero, because the compare then fires on the first step after the wrap. The bench programs both cases. It then counts the high cycles over whole periods: a compare value equal to the period must give 0 high cycles, and a compare value of zero must give 1 per period. A buffered register swap can also coincide with a wrap. The bench checks that the new width shows up from the following period onward.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

    localparam int unsigned A_CTRL  = 0;
    localparam int unsigned A_TOP   = 1;
    localparam int unsigned A_COUNT = 2;
    localparam int unsigned A_CFG0  = 3;
    localparam int unsigned A_CMP0  = 4;
    localparam int unsigned A_CFG1  = 5;
    localparam int unsigned A_CMP1  = 6;

    typedef struct packed {
        logic       full;
        logic [1:0] act;
        logic       tov;
        logic [1:0] mode;
    } ch_cfg_t;

    typedef enum logic [2:0] {
        LK_SOLO,
        LK_USE0,
        LK_USE0_NXT1,
        LK_USE1,
        LK_USE1_NXT0
    } link_state_t;

    typedef enum logic {
        OUT_LOW,
        OUT_HIGH
    } out_state_t;

endpackage

// File: rtl/pwt_counter.sv
module pwt_counter #(
    parameter int CW  = 16,
    parameter int PSW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           halt,
    input  logic           clr,
    input  logic [PSW-1:0] ps,
    input  logic [CW-1:0]  period,
    output logic [CW-1:0]  count,
    output logic           tick,
    output logic           wrap
);
    localparam int PRE_W = (1 << PSW) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        mask = ~({PRE_W{1'b1}} << ps);
        tick = !halt && !clr && ((pre_q & mask) == mask);
        wrap = tick && (count == period);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            count <= '0;
        end else if (clr) begin
            pre_q <= '0;
            count <= '0;
        end else if (!halt) begin
            pre_q <= pre_q + 1'b1;
            if (tick) begin
                count <= wrap ? '0 : count + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwt_link.sv
module pwt_link
    import pwt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic linked,
    input  logic wrap,
    input  logic wr_cmp0,
    input  logic wr_cmp1,
    output logic sel1
);
    link_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_SOLO;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_SOLO:      if (linked) state_d = LK_USE0;
            LK_USE0:      if (!linked) state_d = LK_SOLO;
                          else if (wr_cmp1) state_d = LK_USE0_NXT1;
            LK_USE0_NXT1: if (!linked) state_d = LK_SOLO;
                          else if (wrap) state_d = LK_USE1;
            LK_USE1:      if (!linked) state_d = LK_SOLO;
                          else if (wr_cmp0) state_d = LK_USE1_NXT0;
            LK_USE1_NXT0: if (!linked) state_d = LK_SOLO;
                          else if (wrap) state_d = LK_USE0;
            default:      state_d = LK_SOLO;
        endcase
    end

    always_comb begin
        sel1 = (state_q == LK_USE1) || (state_q == LK_USE1_NXT0);
    end
endmodule

// File: rtl/pwt_channel.sv
module pwt_channel
    import pwt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       hit,
    input  logic       wrap,
    input  logic       tov,
    input  logic [1:0] act,
    input  logic       full,
    output logic       pin
);
    out_state_t state_q, state_d;
    out_state_t pulse_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OUT_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        pulse_lvl = act[0] ? OUT_LOW : OUT_HIGH;
        state_d   = state_q;
        if (en) begin
            if (full && tov) begin
                if (wrap) state_d = pulse_lvl;
            end else begin
                if (wrap && tov) begin
                    state_d = (state_q == OUT_HIGH) ? OUT_LOW : OUT_HIGH;
                end
                if (hit) begin
                    unique case (act)
                        2'b01:   state_d = (state_d == OUT_HIGH) ? OUT_LOW : OUT_HIGH;
                        2'b10:   state_d = OUT_LOW;
                        2'b11:   state_d = OUT_HIGH;
                        default: state_d = state_d;
                    endcase
                end
            end
        end
    end

    always_comb begin
        pin = (act != 2'b00) && (state_q == OUT_HIGH);
    end
endmodule

// File: rtl/pwm_pair_timer.sv
module pwm_pair_timer
    import pwt_pkg::*;
#(
    parameter int CW  = 16,
    parameter int PSW = 3,
    parameter int AW  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] rdata,
    output logic [1:0]    pwm_out
);
    localparam int NCH = 2;
    localparam int CFW = $bits(ch_cfg_t);

    logic           halt_q;
    logic [PSW-1:0] ps_q;
    logic [CW-1:0]  period_q;
    ch_cfg_t        cfg_q [NCH];
    logic [CW-1:0]  cmp_q [NCH];

    logic           clr_w, tick_w, wrap_w, sel1_w, linked_w;
    logic [CW-1:0]  count_w;
    logic [NCH-1:0] pin_raw;
    logic           wr_cmp0, wr_cmp1;

    always_comb begin
        clr_w    = wr_en && (addr == AW'(A_CTRL)) && wdata[1];
        wr_cmp0  = wr_en && (addr == AW'(A_CMP0));
        wr_cmp1  = wr_en && (addr == AW'(A_CMP1));
        linked_w = cfg_q[0].mode[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halt_q   <= 1'b0;
            ps_q     <= '0;
            period_q <= '1;
            for (int i = 0; i < NCH; i++) begin
                cfg_q[i] <= '0;
                cmp_q[i] <= '0;
            end
        end else if (wr_en) begin
            if (addr == AW'(A_CTRL)) begin
                halt_q <= wdata[0];
                ps_q   <= wdata[2 +: PSW];
            end
            if (addr == AW'(A_TOP))  period_q <= wdata;
            if (addr == AW'(A_CFG0)) cfg_q[0] <= ch_cfg_t'(wdata[CFW-1:0]);
            if (addr == AW'(A_CFG1)) cfg_q[1] <= ch_cfg_t'(wdata[CFW-1:0]);
            if (wr_cmp0)             cmp_q[0] <= wdata;
            if (wr_cmp1)             cmp_q[1] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            AW'(A_CTRL):  rdata = CW'({ps_q, 1'b0, halt_q});
            AW'(A_TOP):   rdata = period_q;
            AW'(A_COUNT): rdata = count_w;
            AW'(A_CFG0):  rdata = CW'(cfg_q[0]);
            AW'(A_CMP0):  rdata = cmp_q[0];
            AW'(A_CFG1):  rdata = CW'(cfg_q[1]);
            AW'(A_CMP1):  rdata = cmp_q[1];
            default:      rdata = '0;
        endcase
    end

    pwt_counter #(.CW(CW), .PSW(PSW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .halt(halt_q), .clr(clr_w), .ps(ps_q),
        .period(period_q), .count(count_w), .tick(tick_w), .wrap(wrap_w)
    );

    pwt_link u_link (
        .clk(clk), .rst_n(rst_n), .linked(linked_w), .wrap(wrap_w),
        .wr_cmp0(wr_cmp0), .wr_cmp1(wr_cmp1), .sel1(sel1_w)
    );

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        logic [CW-1:0] cmp_use;
        logic          hit, en;
        if (gi == 0) begin : g_lead
            assign cmp_use = sel1_w ? cmp_q[1] : cmp_q[0];
            assign en      = (cfg_q[0].mode != 2'b00);
        end else begin : g_follow
            assign cmp_use = cmp_q[gi];
            assign en      = !linked_w && (cfg_q[gi].mode != 2'b00);
        end
        assign hit = tick_w && (count_w == cmp_use);

        pwt_channel u_ch (
            .clk(clk), .rst_n(rst_n), .en(en), .hit(hit), .wrap(wrap_w),
            .tov(cfg_q[gi].tov), .act(cfg_q[gi].act), .full(cfg_q[gi].full),
            .pin(pin_raw[gi])
        );
    end

    always_comb begin
        pwm_out[0] = pin_raw[0];
        pwm_out[1] = linked_w ? 1'b0 : pin_raw[1];
    end
endmodule

// File: rtl/pwt_checks.sv
module pwt_checks
    import pwt_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          halt,
    input logic          clr,
    input logic          tick,
    input logic [CW-1:0] count,
    input logic [CW-1:0] period,
    input ch_cfg_t       cfg0,
    input logic          pwm0
);
    assert_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !clr) |=> $stable(count));

    assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (count == period) && !clr) |=> (count == '0));

    assert_zero_duty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg0.tov && cfg0.act == 2'b10 && !pwm0 && !wr_en) |=> !pwm0);

    assert_full_duty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg0.tov && cfg0.full && cfg0.act == 2'b10 && pwm0 && !wr_en) |=> pwm0);
endmodule

bind pwm_pair_timer pwt_checks #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .halt(halt_q), .clr(clr_w),
    .tick(tick_w), .count(count_w), .period(period_q), .cfg0(cfg_q[0]),
    .pwm0(pwm_out[0])
);

// File: tb/pwm_pair_timer_test.sv
`timescale 1ns/1ps
module pwm_pair_timer_test;
    localparam int P  = 9;
    localparam int NP = 8;
    localparam int WIN = NP * (P + 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [1:0]  pwm_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwm_pair_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hw_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = 3'(a);
        wdata = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        addr = 3'(a);
        #1;
        v = int'(rdata);
    endtask

    task automatic highs(input int ch, output int h);
        h = 0;
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            if (pwm_out[ch]) h++;
        end
    endtask

    // reset, halt, program period, compare and control, run with prescale 1
    task automatic setup_ch(input int ch, input int cmp, input int cfg);
        hw_reset();
        wr(0, 1);
        wr(1, P);
        wr(ch == 0 ? 4 : 6, cmp);
        wr(ch == 0 ? 3 : 5, cfg);
        wr(0, 0);
        repeat (2 * (P + 1)) @(negedge clk);
    endtask

    task automatic t_reset();
        int v;
        hw_reset();
        rd(2, v);
        chk(v == 0 && pwm_out == 2'b00, "R1 reset count/pins", v, 0);
    endtask

    task automatic t_halt_clear();
        int a, b;
        hw_reset();
        repeat (20) @(negedge clk);
        wr(0, 1);
        rd(2, a);
        repeat (10) @(negedge clk);
        rd(2, b);
        chk(a == b && a != 0, "R1 halt freezes count", b, a);
        wr(0, 3);
        rd(2, b);
        chk(b == 0, "R2 clear zeroes count", b, 0);
        rd(0, a);
        chk(a[1] == 1'b0, "R2 clear bit reads 0", a[1], 0);
    endtask

    task automatic t_wrap();
        int v, prev, mx;
        bit ok;
        hw_reset();
        wr(0, 3);
        wr(1, 5);
        wr(0, 0);
        mx = 0; ok = 1'b1; prev = -1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            rd(2, v);
            if (v > mx) mx = v;
            if (prev == 5 && v != 0) ok = 1'b0;
            prev = v;
        end
        chk(mx == 5, "R3 counter peaks at period", mx, 5);
        chk(ok, "R3 wrap to zero after period", prev, 0);
    endtask

    task automatic t_prescale();
        int v;
        hw_reset();
        wr(0, 3);
        wr(1, 16'hFFFF);
        wr(0, 2 << 2);
        repeat (39) @(negedge clk);
        rd(2, v);
        chk(v >= 9 && v <= 11, "R3 prescale divide by 4", v, 10);
    endtask

    task automatic t_unbuf();
        int h;
        setup_ch(0, 3, 'h15);
        highs(0, h);
        chk(h == NP * 4, "R5 clear-on-compare C=3", h, NP * 4);
        setup_ch(0, 6, 'h15);
        highs(0, h);
        chk(h == NP * 7, "R5 clear-on-compare C=6", h, NP * 7);
        setup_ch(0, 3, 'h1D);
        highs(0, h);
        chk(h == NP * 6, "R5 set-on-compare C=3", h, NP * 6);
        setup_ch(1, 2, 'h15);
        highs(1, h);
        chk(h == NP * 3, "R4 channel 1 compare C=2", h, NP * 3);
    endtask

    task automatic t_extremes();
        int h;
        setup_ch(0, 3, 'h11);
        highs(0, h);
        chk(h == 0, "R6 zero duty", h, 0);
        setup_ch(0, 3, 'h35);
        highs(0, h);
        chk(h == WIN, "R7 full duty", h, WIN);
        setup_ch(0, 3, 'h05);
        highs(0, h);
        chk(h == 0, "R9 action 00 pin low", h, 0);
    endtask

    task automatic t_coincide();
        int h;
        setup_ch(0, P, 'h15);
        highs(0, h);
        chk(h == 0, "R8 compare equals period", h, 0);
        setup_ch(0, 0, 'h15);
        highs(0, h);
        chk(h == NP, "R8 compare at zero", h, NP);
    endtask

    task automatic t_buffered();
        int h, h1;
        hw_reset();
        wr(0, 1);
        wr(1, P);
        wr(4, 3);
        wr(6, 6);
        wr(5, 'h15);
        wr(3, 'h16);
        wr(0, 0);
        repeat (2 * (P + 1)) @(negedge clk);
        fork
            highs(0, h);
            highs(1, h1);
        join
        chk(h == NP * 4, "R10 channel 0 register active first", h, NP * 4);
        chk(h1 == 0, "R10 pin 1 low while linked", h1, 0);
        wr(6, 6);
        repeat (2 * (P + 1)) @(negedge clk);
        highs(0, h);
        chk(h == NP * 7, "R11 swap to channel 1 register", h, NP * 7);
        wr(4, 1);
        repeat (2 * (P + 1)) @(negedge clk);
        highs(0, h);
        chk(h == NP * 2, "R11 swap back to channel 0 register", h, NP * 2);
        wr(4, 5);
        repeat (2 * (P + 1)) @(negedge clk);
        highs(0, h);
        chk(h == NP * 6, "R12 active write, no swap", h, NP * 6);
        wr(3, 'h17);
        repeat (2 * (P + 1)) @(negedge clk);
        highs(1, h1);
        chk(h1 == 0, "R10 mode 11 still linked", h1, 0);
    endtask

    initial begin
        t_reset();
        t_halt_clear();
        t_wrap();
        t_prescale();
        t_unbuf();
        t_extremes();
        t_coincide();
        t_buffered();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule